// File: doc/BRIEF.md
# Disk Transfer Address Sequencer

This block keeps track of the memory side and the disk side of a multi-sector disk transfer. A parameter command carries a pointer into memory. The block then fetches two consecutive words over a one-request-at-a-time DMA port. The first word becomes the transfer word count and the second becomes the starting buffer address. A start command loads the track, sets the busy flag and clears done. During the transfer the sector engine sends one strobe per word. The block forms the 15-bit memory address from a fixed bank field and a 12-bit pointer that wraps inside its 4K bank, and it counts the remaining words. After each good sector it steps a 15-bit disk address made of track and sector. An error, or a completed sector with no words left, ends the transfer and raises done. The interrupt request follows done gated by the interrupt enable.

The controller has four states. In `ST_IDLE` a load command moves it to `ST_FETCH_WC` and a start command moves it to `ST_XFER`. In `ST_FETCH_WC` a grant moves it to `ST_FETCH_CA`, and in `ST_FETCH_CA` a grant returns it to `ST_IDLE`. In `ST_XFER` an error, or a sector completion that leaves no words, returns it to `ST_IDLE`. Every other condition holds the current state.

Top module: `dsq_top`

## Requirements
- R1: With `cmd_op`=1 (load) in idle, `cmd_word` is taken as a pointer P. `dma_req` rises with `mem_addr`={bank,P}. On the first `dma_gnt`, `dma_rdata` becomes the word count and the request moves to {bank,(P+1) mod 4096}. On the second grant, `dma_rdata` becomes the current address and `dma_req` drops.
- R2: During a transfer `mem_addr` equals {bank,current address}. Each counted word strobe advances the current address by one, and the address wraps from 0xFFF to 0x000 without changing the bank.
- R3: A loaded word count of 0 means 4096 words. `words_left` stays high until that many strobes have been counted. Strobes after the count is reached do not move the current address.
- R4: `disk_addr` equals {`cmd_word`[10:0] captured at start, 4-bit sector}. The sector is loaded by `sec_we` in idle. The address steps by one after each good sector, so sector 15 wraps to 0 and carries into the track LSB.
- R5: A start with `cmd_op`=2 (read) or 3 (write) sets `busy`, clears `done`, and sets `xfer_rd` to 1 for read and 0 for write. `busy` and `done` are never high together.
- R6: `sec_done` with no words left ends the transfer: `busy` goes to 0 and `done` goes to 1. `sec_done` with words still left keeps `busy` high.
- R7: `sec_err` during a transfer ends it with `done` set and leaves `disk_addr` unchanged.
- R8: `irq` is high exactly when `done` and the stored interrupt enable are both set.
- R9: Reset clears `busy`, `done`, `irq`, the interrupt enable and `fmt_en`.
- R10: Load and start commands are ignored unless the block is idle. `dma_req` is never high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master clear |
| cmd_op | input | 2 | 0 none, 1 load parameters, 2 start read, 3 start write |
| cmd_word | input | 12 | Pointer for load; track word for start |
| ctl_we | input | 1 | Write bank, interrupt enable and format enable |
| ctl_bank | input | 3 | Memory bank field |
| ctl_ie | input | 1 | Interrupt enable value |
| ctl_fmt | input | 1 | Format enable value |
| sec_we | input | 1 | Load starting sector (idle only) |
| sec_val | input | 4 | Starting sector |
| dma_req | output | 1 | DMA read request, held until granted |
| dma_gnt | input | 1 | DMA grant strobe, data valid |
| dma_rdata | input | 12 | DMA read data |
| mem_addr | output | 15 | Bank plus current address |
| word_stb | input | 1 | One data word moved |
| words_left | output | 1 | Word count not yet exhausted |
| sec_done | input | 1 | Sector finished good |
| sec_err | input | 1 | Sector engine error |
| disk_addr | output | 15 | Track and sector address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |
| irq | output | 1 | Interrupt request |
| xfer_rd | output | 1 | 1 read, 0 write |
| fmt_en | output | 1 | Stored format enable |

## Verification
The bench drives the 4K wrap from both sides: a fetch pointer at 0xFFF whose second word must come from 0x000, and a buffer that crosses 0xFFF. A design that carried into the bank would show an address in the wrong bank. A word count of zero is run through all 4096 strobes, and words_left is checked at 4095 and at 4096. A design that treated zero as an empty count would finish at once, and one that stopped early would drop the flag at 4095. A sector start of 14 crosses 15 into the head-select bit, which shows whether the carry into the track is dropped. An error in mid-transfer checks that done is set and that the disk address does not advance. Commands issued during a fetch or a transfer must leave the state unchanged.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LOAD = 2'd1,
        OP_RD   = 2'd2,
        OP_WR   = 2'd3
    } op_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH_WC,
        ST_FETCH_CA,
        ST_XFER
    } state_t;
endpackage

// File: rtl/dsq_word_addr.sv
module dsq_word_addr #(
    parameter int CA_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_ptr,
    input  logic [CA_W-1:0] ptr,
    input  logic            inc_ca,
    input  logic            ld_wc,
    input  logic [CA_W-1:0] wc_val,
    input  logic            dec_wc,
    output logic [CA_W-1:0] ca,
    output logic            rem_nz,
    output logic            rem_empty_next
);
    localparam int RW = CA_W + 1;
    localparam logic [RW-1:0] FULL = {1'b1, {CA_W{1'b0}}};

    logic [RW-1:0] rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ca <= '0;
        end else if (ld_ptr) begin
            ca <= ptr;
        end else if (inc_ca) begin
            ca <= ca + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (ld_wc) begin
            rem <= (wc_val == '0) ? FULL : {1'b0, wc_val};
        end else if (dec_wc && rem != '0) begin
            rem <= rem - 1'b1;
        end
    end

    assign rem_nz         = (rem != '0);
    assign rem_empty_next = (rem == '0) || (rem == RW'(1) && dec_wc);

    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rem <= FULL); // R3
    AST_CA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_ca && !ld_ptr) |=> ca == CA_W'($past(ca) + 1'b1)); // R2
endmodule

// File: rtl/dsq_disk_addr.sv
module dsq_disk_addr #(
    parameter int TRK_W = 11,
    parameter int SEC_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_trk,
    input  logic [TRK_W-1:0]       trk,
    input  logic                   ld_sec,
    input  logic [SEC_W-1:0]       sec,
    input  logic                   adv,
    output logic [TRK_W+SEC_W-1:0] addr
);
    localparam int AW = TRK_W + SEC_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (ld_trk || ld_sec) begin
            addr <= {ld_trk ? trk : addr[AW-1:SEC_W],
                     ld_sec ? sec : addr[SEC_W-1:0]};
        end else if (adv) begin
            addr <= addr + 1'b1;
        end
    end

    AST_DISK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld_trk && !ld_sec) |=> addr == AW'($past(addr) + 1'b1)); // R4
endmodule

// File: rtl/dsq_top.sv
module dsq_top #(
    parameter int CA_W   = 12,
    parameter int BANK_W = 3,
    parameter int TRK_W  = 11,
    parameter int SEC_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              cmd_op,
    input  logic [CA_W-1:0]         cmd_word,
    input  logic                    ctl_we,
    input  logic [BANK_W-1:0]       ctl_bank,
    input  logic                    ctl_ie,
    input  logic                    ctl_fmt,
    input  logic                    sec_we,
    input  logic [SEC_W-1:0]        sec_val,
    output logic                    dma_req,
    input  logic                    dma_gnt,
    input  logic [CA_W-1:0]         dma_rdata,
    output logic [BANK_W+CA_W-1:0]  mem_addr,
    input  logic                    word_stb,
    output logic                    words_left,
    input  logic                    sec_done,
    input  logic                    sec_err,
    output logic [TRK_W+SEC_W-1:0]  disk_addr,
    output logic                    busy,
    output logic                    done,
    output logic                    irq,
    output logic                    xfer_rd,
    output logic                    fmt_en
);
    import dsq_pkg::*;

    state_t            state, nxt;
    logic              ld_ptr, inc_ca, ld_wc, dec_wc, start, finish, adv;
    logic [CA_W-1:0]   ptr, ca;
    logic              rem_empty_next;
    logic [BANK_W-1:0] bank;
    logic              ie;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt     = state;
        dma_req = 1'b0;
        ld_ptr  = 1'b0;
        ptr     = cmd_word;
        inc_ca  = 1'b0;
        ld_wc   = 1'b0;
        dec_wc  = 1'b0;
        start   = 1'b0;
        finish  = 1'b0;
        adv     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_op == OP_LOAD) begin
                    ld_ptr = 1'b1;
                    nxt    = ST_FETCH_WC;
                end else if (cmd_op == OP_RD || cmd_op == OP_WR) begin
                    start = 1'b1;
                    nxt   = ST_XFER;
                end
            end
            ST_FETCH_WC: begin
                dma_req = 1'b1;
                if (dma_gnt) begin
                    ld_wc  = 1'b1;
                    inc_ca = 1'b1;
                    nxt    = ST_FETCH_CA;
                end
            end
            ST_FETCH_CA: begin
                dma_req = 1'b1;
                if (dma_gnt) begin
                    ld_ptr = 1'b1;
                    ptr    = dma_rdata;
                    nxt    = ST_IDLE;
                end
            end
            ST_XFER: begin
                dec_wc = word_stb && words_left;
                inc_ca = dec_wc;
                if (sec_err) begin
                    finish = 1'b1;
                    nxt    = ST_IDLE;
                end else if (sec_done) begin
                    adv = 1'b1;
                    if (rem_empty_next) begin
                        finish = 1'b1;
                        nxt    = ST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            ie      <= 1'b0;
            fmt_en  <= 1'b0;
            xfer_rd <= 1'b0;
            bank    <= '0;
        end else begin
            if (ctl_we) begin
                bank   <= ctl_bank;
                ie     <= ctl_ie;
                fmt_en <= ctl_fmt;
            end
            if (start) begin
                done    <= 1'b0;
                xfer_rd <= (cmd_op == OP_RD);
            end
            if (finish) done <= 1'b1;
        end
    end

    assign busy     = (state == ST_XFER);
    assign irq      = done && ie;
    assign mem_addr = {bank, ca};

    dsq_word_addr #(.CA_W(CA_W)) u_word (
        .clk(clk), .rst_n(rst_n),
        .ld_ptr(ld_ptr), .ptr(ptr), .inc_ca(inc_ca),
        .ld_wc(ld_wc), .wc_val(dma_rdata), .dec_wc(dec_wc),
        .ca(ca), .rem_nz(words_left), .rem_empty_next(rem_empty_next)
    );

    dsq_disk_addr #(.TRK_W(TRK_W), .SEC_W(SEC_W)) u_disk (
        .clk(clk), .rst_n(rst_n),
        .ld_trk(start), .trk(cmd_word[TRK_W-1:0]),
        .ld_sec(sec_we && state == ST_IDLE), .sec(sec_val),
        .adv(adv), .addr(disk_addr)
    );

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R5
    AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> !busy); // R10
    AST_DONE_FROM_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R6
    AST_START_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_op[1]) |=> (busy && !done)); // R5
endmodule

// File: tb/test_dsq_top.sv
module test_dsq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [11:0] cmd_word = '0;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_bank = '0;
    logic        ctl_ie = 1'b0, ctl_fmt = 1'b0;
    logic        sec_we = 1'b0;
    logic [3:0]  sec_val = '0;
    logic        dma_req, dma_gnt = 1'b0;
    logic [11:0] dma_rdata = '0;
    logic [14:0] mem_addr;
    logic        word_stb = 1'b0, words_left;
    logic        sec_done = 1'b0, sec_err = 1'b0;
    logic [14:0] disk_addr;
    logic        busy, done, irq, xfer_rd, fmt_en;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [14:0] exp_q[$];
    logic [11:0] exp_ca;

    always #5 clk = ~clk;

    dsq_top i_dsq_top (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_word(cmd_word),
        .ctl_we(ctl_we), .ctl_bank(ctl_bank), .ctl_ie(ctl_ie), .ctl_fmt(ctl_fmt),
        .sec_we(sec_we), .sec_val(sec_val), .dma_req(dma_req), .dma_gnt(dma_gnt),
        .dma_rdata(dma_rdata), .mem_addr(mem_addr), .word_stb(word_stb),
        .words_left(words_left), .sec_done(sec_done), .sec_err(sec_err),
        .disk_addr(disk_addr), .busy(busy), .done(done), .irq(irq),
        .xfer_rd(xfer_rd), .fmt_en(fmt_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // monitor: compares the address presented for each counted word
    always @(posedge clk) begin
        if (rst_n && word_stb && words_left) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2 actual=%0h expected=none", mem_addr);
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                if (mem_addr !== e) begin
                    fails++;
                    $display("FAIL R2 actual=%0h expected=%0h", mem_addr, e);
                end
            end
        end
    end

    // driver: pushes the expected address and strobes one word
    task automatic word(input logic [2:0] bnk);
        exp_q.push_back({bnk, exp_ca});
        exp_ca = exp_ca + 1'b1;
        word_stb = 1'b1; tick(); word_stb = 1'b0;
    endtask

    task automatic cmd(input logic [1:0] op, input logic [11:0] w);
        cmd_op = op; cmd_word = w; tick(); cmd_op = 2'd0;
    endtask

    task automatic grant(input logic [11:0] d);
        dma_gnt = 1'b1; dma_rdata = d; tick(); dma_gnt = 1'b0;
    endtask

    task automatic ctl(input logic [2:0] b, input logic ie, input logic fm);
        ctl_we = 1'b1; ctl_bank = b; ctl_ie = ie; ctl_fmt = fm; tick(); ctl_we = 1'b0;
    endtask

    task automatic sdone();
        sec_done = 1'b1; tick(); sec_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        check("R9 busy", busy, 0);
        check("R9 done", done, 0);
        check("R9 irq", irq, 0);
        check("R9 fmt", fmt_en, 0);
        rst_n = 1'b1;
        tick();
        ctl(3'd3, 1'b1, 1'b1);
        check("R9 fmt write", fmt_en, 1);

        // R1 parameter fetch
        cmd(2'd1, 12'h123);
        check("R1 req", dma_req, 1);
        check("R1 first addr", mem_addr, 15'h3123);
        cmd(2'd2, 12'h000);
        check("R10 start during fetch", busy, 0);
        check("R10 still fetching", dma_req, 1);
        grant(12'd5);
        check("R1 second addr", mem_addr, 15'h3124);
        grant(12'hFFE);
        check("R1 req drop", dma_req, 0);
        check("R1 ca loaded", mem_addr, 15'h3FFE);

        // R4 sector 14, start read on track 5
        sec_we = 1'b1; sec_val = 4'd14; tick(); sec_we = 1'b0;
        cmd(2'd2, 12'h005);
        check("R5 busy", busy, 1);
        check("R5 done", done, 0);
        check("R5 read dir", xfer_rd, 1);
        check("R4 disk start", disk_addr, 15'h005E);
        cmd(2'd1, 12'h444);
        check("R10 load while busy", dma_req, 0);
        exp_ca = 12'hFFE;
        for (int i = 0; i < 3; i++) word(3'd3);
        sdone();
        check("R6 continue", busy, 1);
        check("R4 step", disk_addr, 15'h005F);
        for (int i = 0; i < 2; i++) word(3'd3);
        check("R3 count out", words_left, 0);
        word_stb = 1'b1; tick(); word_stb = 1'b0;
        check("R3 extra strobe", mem_addr, 15'h3003);
        sdone();
        check("R6 end busy", busy, 0);
        check("R6 end done", done, 1);
        check("R4 carry", disk_addr, 15'h0060);
        check("R8 irq on", irq, 1);
        ctl(3'd3, 1'b0, 1'b1);
        check("R8 irq off", irq, 0);

        // R1 wrap of the fetch pointer, R3 count of zero
        cmd(2'd1, 12'hFFF);
        check("R1 addr fff", mem_addr, 15'h3FFF);
        grant(12'd0);
        check("R1 wrap", mem_addr, 15'h3000);
        grant(12'h100);
        cmd(2'd3, 12'h7FF);
        check("R5 write dir", xfer_rd, 0);
        check("R4 track load", disk_addr, 15'h7FF0);
        exp_ca = 12'h100;
        for (int i = 0; i < 4095; i++) word(3'd3);
        check("R3 4095", words_left, 1);
        word(3'd3);
        check("R3 4096", words_left, 0);
        check("R2 bank wrap", mem_addr, 15'h3100);
        sdone();
        check("R6 done big", done, 1);
        check("R4 step big", disk_addr, 15'h7FF1);

        // R7 error
        ctl(3'd3, 1'b1, 1'b1);
        cmd(2'd1, 12'h200);
        grant(12'd3);
        grant(12'h050);
        cmd(2'd2, 12'h001);
        exp_ca = 12'h050;
        word(3'd3);
        sec_err = 1'b1; tick(); sec_err = 1'b0;
        check("R7 busy", busy, 0);
        check("R7 done", done, 1);
        check("R7 disk hold", disk_addr, 15'h0011);
        check("R8 irq err", irq, 1);

        // R9 reset during a transfer
        cmd(2'd2, 12'h001);
        check("R9 pre busy", busy, 1);
        rst_n = 1'b0; tick();
        check("R9 busy clr", busy, 0);
        check("R9 done clr", done, 0);
        check("R9 irq clr", irq, 0);
        check("R9 fmt clr", fmt_en, 0);
        rst_n = 1'b1; tick();
        check("R2 queue empty", exp_q.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule